// File: doc/BRIEF.md
# Coarse-Grained Reconfigurable Execution Array

This block is a matrix of word-level ALUs arranged in levels. It executes one configuration per run. The configuration is prepared elsewhere and presented on a flat configuration input. When a run starts, the block snapshots the whole core register file into an input context. During the next cycle, operands flow through every level in one combinational pass. Each level sees the register view that the levels before it leave behind. The per-unit results are then captured in an output context. They are committed back to the register file one level per cycle, through a small number of write lanes.

Inside a level, all ALU slots run concurrently and read the same incoming register view. A later level reads the most recent value of each register. Only a result that no later unit overwrites is written back, and it is written in the cycle that belongs to the level that produced it. Each unit carries an enable bit in its configuration. A unit whose bit is clear is powered down: its operands are forced to zero, it drives zero, it writes nothing and it leaves the register view untouched. A one-cycle completion pulse follows the last level's write cycle.

The register file itself, the source of the configurations and the translator that builds them all sit outside this block.

Top module: `cgra_exec_array`

## Requirements
- R1: A start seen while idle latches rf_snapshot and cfg_in. Any change on those inputs after that edge does not alter the results of the run.
- R2: Each enabled unit reads its sources from the register view at the entry of its level. That value is the one written by the highest-numbered enabled unit of the nearest earlier level that targets the register, or the snapshot value if no earlier unit does.
- R3: Op encodings (3 bits): 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 shift A left by B[3:0], 6 logical shift A right by B[3:0], 7 pass A. Results wrap to W bits.
- R4: The unit at index u = level*NALU + slot uses cfg_in[u*13 +: 13]. Bit 12 is the enable, bits 11:9 the op, bits 8:6 source A, bits 5:3 source B and bits 2:0 the destination.
- R5: Results of level l appear on the write lanes exactly in the (l+2)-th cycle after the start edge. Final results are placed in ascending slot order from lane 0 upward, and no lane is enabled outside these cycles.
- R6: A disabled unit writes nothing and does not change the register view seen by later levels.
- R7: done is a one-cycle pulse in the cycle after the last level's write cycle. busy is high from the cycle after the start edge through the done cycle. A start seen while busy is ignored.
- R8: After reset, busy, done and every wb_en bit are low.
- R9: Only final results are written back. A unit's result is final if no enabled unit with a higher index targets the same register. Between two same-level units with the same destination, the higher slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| cfg_in | input | NLEV*NALU*13 | Flat configuration, one 13-bit entry per unit |
| rf_snapshot | input | NREGS*W | Register file read view, register r at bits r*W +: W |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | WB_PORTS | Write-lane valid bits |
| wb_addr | output | WB_PORTS*3 | Write-lane register numbers |
| wb_data | output | WB_PORTS*W | Write-lane data |

## Verification
The assertions assume that a configuration never marks more final results in one level than there are write lanes. The translator is expected to guarantee this, and the block does not check it. The bench keeps within this limit when it builds random configurations. From the lane count onward, it forces each slot's destination to copy the destination of a lower slot in the same level. That leaves at most two distinct destinations per level. The directed cases stay within the same limit by hand.

// File: rtl/cgra_pkg.sv
package cgra_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SLL  = 3'd5,
    OP_SRL  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } arr_state_e;
endpackage

// File: rtl/cgra_fu.sv
module cgra_fu
  import cgra_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            en,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] alu_eval(alu_op_e f, logic [W-1:0] x, logic [W-1:0] z);
    case (f)
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      OP_SLL:  return x << z[SHW-1:0];
      OP_SRL:  return x >> z[SHW-1:0];
      default: return x;
    endcase
  endfunction

  // power gating: operands held at zero and output forced low when off
  logic [W-1:0] a_g, b_g;
  always_comb begin
    a_g = en ? a : '0;
    b_g = en ? b : '0;
    y   = en ? alu_eval(alu_op_e'(op), a_g, b_g) : '0;
  end
endmodule

// File: rtl/cgra_level.sv
module cgra_level
  import cgra_pkg::*;
#(
  parameter int W     = 16,
  parameter int NREGS = 8,
  parameter int NALU  = 3,
  parameter int RB    = 3,
  parameter int CW    = 13
) (
  input  logic [NREGS*W-1:0] bus_in,
  input  logic [NALU*CW-1:0] lcfg,
  output logic [NREGS*W-1:0] bus_out,
  output logic [NALU*W-1:0]  res
);
  logic [NALU-1:0]    en_v;
  logic [NALU*RB-1:0] dst_v;

  for (genvar s = 0; s < NALU; s++) begin : g_slot
    logic [CW-1:0]   ent;
    logic [RB-1:0]   sa, sb;
    logic [OP_W-1:0] op;
    assign ent = lcfg[s*CW +: CW];
    assign en_v[s] = ent[CW-1];
    assign op  = ent[CW-2 -: OP_W];
    assign sa  = ent[3*RB-1 -: RB];
    assign sb  = ent[2*RB-1 -: RB];
    assign dst_v[s*RB +: RB] = ent[RB-1:0];

    cgra_fu #(.W(W)) u_fu (
      .en(en_v[s]),
      .op(op),
      .a(bus_in[sa*W +: W]),
      .b(bus_in[sb*W +: W]),
      .y(res[s*W +: W])
    );
  end

  // register view handed to the next level; higher slot wins a shared destination
  always_comb begin
    bus_out = bus_in;
    for (int s = 0; s < NALU; s++)
      if (en_v[s]) bus_out[dst_v[s*RB +: RB]*W +: W] = res[s*W +: W];
  end
endmodule

// File: rtl/cgra_wb_sched.sv
module cgra_wb_sched #(
  parameter int W    = 16,
  parameter int NALU = 3,
  parameter int RB   = 3,
  parameter int WBP  = 2
) (
  input  logic [NALU-1:0]    fin,
  input  logic [NALU*RB-1:0] dst,
  input  logic [NALU*W-1:0]  res,
  output logic [WBP-1:0]     lane_en,
  output logic [WBP*RB-1:0]  lane_addr,
  output logic [WBP*W-1:0]   lane_data
);
  always_comb begin
    int n;
    n = 0;
    lane_en   = '0;
    lane_addr = '0;
    lane_data = '0;
    for (int s = 0; s < NALU; s++) begin
      if (fin[s] && n < WBP) begin
        lane_en[n]            = 1'b1;
        lane_addr[n*RB +: RB] = dst[s*RB +: RB];
        lane_data[n*W +: W]   = res[s*W +: W];
        n = n + 1;
      end
    end
  end
endmodule

// File: rtl/cgra_exec_array.sv
module cgra_exec_array
  import cgra_pkg::*;
#(
  parameter int W        = 16,
  parameter int NREGS    = 8,
  parameter int NLEV     = 3,
  parameter int NALU     = 3,
  parameter int WB_PORTS = 2,
  localparam int RB      = $clog2(NREGS),
  localparam int CW      = 1 + OP_W + 3*RB,
  localparam int NU      = NLEV*NALU
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NU*CW-1:0]       cfg_in,
  input  logic [NREGS*W-1:0]     rf_snapshot,
  output logic                   busy,
  output logic                   done,
  output logic [WB_PORTS-1:0]    wb_en,
  output logic [WB_PORTS*RB-1:0] wb_addr,
  output logic [WB_PORTS*W-1:0]  wb_data
);
  localparam int LVW = (NLEV > 1) ? $clog2(NLEV) : 1;

  arr_state_e         state;
  logic [NREGS*W-1:0] ctx_in;
  logic [NU*CW-1:0]   cfg_q;
  logic [NU*W-1:0]    res_q;
  logic [LVW-1:0]     lvl_q;

  // named events for the checker
  logic accept, exec_fire, last_wb;
  assign accept    = start && (state == ST_IDLE);
  assign exec_fire = (state == ST_EXEC);
  assign last_wb   = (state == ST_WB) && (lvl_q == LVW'(NLEV-1));

  // combinational chain of levels
  logic [(NLEV+1)*NREGS*W-1:0] bus_chain;
  logic [NU*W-1:0]             res_all;
  assign bus_chain[0 +: NREGS*W] = ctx_in;

  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    cgra_level #(.W(W), .NREGS(NREGS), .NALU(NALU), .RB(RB), .CW(CW)) u_lvl (
      .bus_in (bus_chain[l*NREGS*W +: NREGS*W]),
      .lcfg   (cfg_q[l*NALU*CW +: NALU*CW]),
      .bus_out(bus_chain[(l+1)*NREGS*W +: NREGS*W]),
      .res    (res_all[l*NALU*W +: NALU*W])
    );
  end

  // per-unit enable and destination views of the held configuration
  logic [NU-1:0]    u_en;
  logic [NU*RB-1:0] u_dst;
  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign u_en[u]           = cfg_q[u*CW + CW-1];
    assign u_dst[u*RB +: RB] = cfg_q[u*CW +: RB];
  end

  // a result is final when no later enabled unit targets the same register
  logic [NU-1:0] fin_c;
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      fin_c[u] = u_en[u];
      for (int v = u + 1; v < NU; v++)
        if (u_en[v] && u_dst[v*RB +: RB] == u_dst[u*RB +: RB]) fin_c[u] = 1'b0;
    end
  end

  logic [WB_PORTS-1:0]    lane_en;
  logic [WB_PORTS*RB-1:0] lane_addr;
  logic [WB_PORTS*W-1:0]  lane_data;

  cgra_wb_sched #(.W(W), .NALU(NALU), .RB(RB), .WBP(WB_PORTS)) u_wb (
    .fin      (fin_c[lvl_q*NALU +: NALU]),
    .dst      (u_dst[lvl_q*NALU*RB +: NALU*RB]),
    .res      (res_q[lvl_q*NALU*W +: NALU*W]),
    .lane_en  (lane_en),
    .lane_addr(lane_addr),
    .lane_data(lane_data)
  );

  assign wb_en   = (state == ST_WB) ? lane_en : '0;
  assign wb_addr = lane_addr;
  assign wb_data = lane_data;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ctx_in <= '0;
      cfg_q  <= '0;
      res_q  <= '0;
      lvl_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          ctx_in <= rf_snapshot;
          cfg_q  <= cfg_in;
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q <= res_all;
          lvl_q <= '0;
          state <= ST_WB;
        end
        ST_WB: begin
          if (last_wb) state <= ST_DONE;
          else         lvl_q <= lvl_q + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cgra_exec_array_chk.sv
module cgra_exec_array_chk #(
  parameter int WB_PORTS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [WB_PORTS-1:0] wb_en,
  input logic                accept,
  input logic                last_wb
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_wb));

  p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !done));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);

  p_lanes_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wb_en == '0));

  p_lane_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en & (wb_en + 1'b1)) == '0);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && wb_en == '0));
endmodule

bind cgra_exec_array cgra_exec_array_chk #(.WB_PORTS(WB_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wb_en(wb_en), .accept(accept), .last_wb(last_wb)
);

// File: tb/tb_cgra_exec_array.sv
module tb_cgra_exec_array;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, NREGS = 8, NLEV = 3, NALU = 3, WBP = 2;
  localparam int RB = 3, CW = 13, NU = NLEV*NALU;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NU*CW-1:0]    cfg_in = '0;
  logic [NREGS*W-1:0]  rf_snapshot = '0;
  logic busy, done;
  logic [WBP-1:0]      wb_en;
  logic [WBP*RB-1:0]   wb_addr;
  logic [WBP*W-1:0]    wb_data;

  int vectors = 0, miscompares = 0, cycles = 0;

  cgra_exec_array dut (.clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .rf_snapshot(rf_snapshot), .busy(busy), .done(done), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected write lanes per level
  int exp_n[NLEV];
  int exp_a[NLEV][WBP];
  int exp_d[NLEV][WBP];
  int regs[NREGS];

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_alu(int op, int a, int b);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a << (b % 16);
      6: r = a >>> (b % 16);
      default: r = a;
    endcase
    return r & 32'hFFFF;
  endfunction

  function automatic logic [CW-1:0] ent(int en, int op, int sa, int sb, int d);
    return {en[0], op[2:0], sa[2:0], sb[2:0], d[2:0]};
  endfunction

  // behavioural reference: walk the levels, then pick finals per level
  task automatic predict(logic [NU*CW-1:0] c);
    int view[NREGS];
    int nxt[NREGS];
    int val[NU];
    foreach (view[i]) view[i] = regs[i];
    for (int l = 0; l < NLEV; l++) begin
      foreach (nxt[i]) nxt[i] = view[i];
      for (int s = 0; s < NALU; s++) begin
        logic [CW-1:0] e;
        e = c[(l*NALU+s)*CW +: CW];
        val[l*NALU+s] = ref_alu(int'(e[11:9]), view[e[8:6]], view[e[5:3]]);
        if (e[12]) nxt[e[2:0]] = val[l*NALU+s];
      end
      foreach (view[i]) view[i] = nxt[i];
    end
    for (int l = 0; l < NLEV; l++) begin
      exp_n[l] = 0;
      for (int s = 0; s < NALU; s++) begin
        int u;
        bit fin;
        u = l*NALU + s;
        fin = c[u*CW + 12];
        for (int v = u + 1; v < NU; v++)
          if (c[v*CW + 12] && c[v*CW +: 3] == c[u*CW +: 3]) fin = 0;
        if (fin && exp_n[l] < WBP) begin
          exp_a[l][exp_n[l]] = int'(c[u*CW +: 3]);
          exp_d[l][exp_n[l]] = val[u];
          exp_n[l]++;
        end
      end
    end
  endtask

  task automatic run_case(logic [NU*CW-1:0] c, string req, bit poke);
    logic [NREGS*W-1:0] rv;
    for (int i = 0; i < NREGS; i++) rv[i*W +: W] = regs[i][15:0];
    predict(c);
    @(negedge clk);
    start = 1; cfg_in = c; rf_snapshot = rv;
    @(negedge clk);                       // execute cycle
    start = 0; cfg_in = ~c; rf_snapshot = ~rv;   // R1: must not matter now
    chk(req, "busy exec", int'(busy), 1);
    chk("R5", "wb_en exec", int'(wb_en), 0);
    for (int k = 0; k < NLEV; k++) begin
      @(negedge clk);                     // write cycle of level k
      start = (poke && k == 0);
      chk("R7", "busy wb", int'(busy), 1);
      chk("R7", "done wb", int'(done), 0);
      for (int p = 0; p < WBP; p++) begin
        chk(req, $sformatf("lvl%0d lane%0d en", k, p), int'(wb_en[p]), int'(p < exp_n[k]));
        if (p < exp_n[k]) begin
          chk(req, $sformatf("lvl%0d lane%0d addr", k, p), int'(wb_addr[p*RB +: RB]), exp_a[k][p]);
          chk(req, $sformatf("lvl%0d lane%0d data", k, p), int'(wb_data[p*W +: W]), exp_d[k][p]);
        end
      end
    end
    @(negedge clk);
    start = 0;
    chk("R7", "done pulse", int'(done), 1);
    chk("R5", "wb_en at done", int'(wb_en), 0);
    @(negedge clk);
    chk("R7", "done low after", int'(done), 0);
    chk("R7", "busy low after", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    miscompares++;
    $display("FAIL R7 watchdog actual=%0d expected<%0d", cycles, 100000);
    finish_run();
  end

  initial begin
    logic [NU*CW-1:0] c;
    repeat (3) @(negedge clk);
    chk("R8", "busy reset", int'(busy), 0);
    chk("R8", "done reset", int'(done), 0);
    chk("R8", "wb_en reset", int'(wb_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "busy after release", int'(busy), 0);
    foreach (regs[i]) regs[i] = 16'h1111 * (i + 1);

    // R2/R4 chain: r1=r0+r1, r2=r1-r3, r4=r2^r0; r5 from level0 overwritten in level2 (R9)
    c = '0;
    c[0*CW +: CW] = ent(1, 0, 0, 1, 1);
    c[1*CW +: CW] = ent(1, 3, 6, 7, 5);
    c[3*CW +: CW] = ent(1, 1, 1, 3, 2);
    c[6*CW +: CW] = ent(1, 4, 2, 0, 4);
    c[7*CW +: CW] = ent(1, 7, 2, 0, 5);
    run_case(c, "R2", 0);

    // R3: every op code in slot 0, r1 and r2 as operands
    regs[1] = 16'h8421; regs[2] = 16'h0013;
    for (int op = 0; op < 8; op++) begin
      c = '0;
      c[0*CW +: CW] = ent(1, op, 1, 2, 7);
      run_case(c, "R3", 0);
    end

    // R6: disabled unit writes nothing and leaves r3 visible to level 1
    c = '0;
    c[0*CW +: CW] = ent(0, 0, 1, 1, 3);
    c[3*CW +: CW] = ent(1, 7, 3, 0, 4);
    run_case(c, "R6", 0);

    // R9: same-level shared destination, slot 1 wins
    c = '0;
    c[0*CW +: CW] = ent(1, 0, 0, 0, 2);
    c[1*CW +: CW] = ent(1, 0, 1, 1, 2);
    c[3*CW +: CW] = ent(1, 7, 2, 0, 3);
    run_case(c, "R9", 0);

    // R1/R7: inputs disturbed after start, extra start while busy
    c = '0;
    c[2*CW +: CW] = ent(1, 0, 5, 6, 0);
    c[8*CW +: CW] = ent(1, 2, 0, 7, 6);
    run_case(c, "R1", 1);

    // R5: random configurations with at most WBP destinations per level
    for (int t = 0; t < 60; t++) begin
      foreach (regs[i]) regs[i] = int'($urandom & 32'hFFFF);
      c = '0;
      for (int l = 0; l < NLEV; l++)
        for (int s = 0; s < NALU; s++) begin
          int d;
          d = (s >= WBP) ? int'(c[(l*NALU + s % WBP)*CW +: 3]) : int'($urandom % NREGS);
          c[(l*NALU+s)*CW +: CW] = ent(int'($urandom % 4 != 0), int'($urandom % 8),
                                       int'($urandom % NREGS), int'($urandom % NREGS), d);
        end
      run_case(c, "R5", 0);
    end
    finish_run();
  end
endmodule